// File: doc/BRIEF.md
# Multi-Cycle Shift-Subtract Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over many clock cycles. It uses one adder/subtractor and one double-width working register. The upper half of that register holds the partial remainder. The lower half starts with the dividend and fills with quotient bits one at a time as the register shifts left. When a division is accepted, the register is loaded with the dividend already moved up one place.

Each of the 32 iterations compares the upper half with the divisor. If the divisor fits, it is subtracted and a 1 is shifted in; otherwise the upper half is kept and a 0 is shifted in. After the last iteration the upper half is read back one place to the right, which undoes the one shift too many. Both halves of the result are then latched into output registers.

Signed division works on magnitudes and fixes the signs at the end: the remainder takes the sign of the dividend, and the quotient is negated when the operand signs differ. A zero divisor does not enter the loop and completes at once with a flag raised.

Top module: `div_unit`

## Requirements
- R1: With the signed input low, the operands are treated as unsigned. The block returns quotient = floor(dividend / divisor) and remainder = dividend mod divisor.
- R2: With the signed input high, the operands are two's complement. The quotient is truncated toward zero, and the remainder has the sign of the dividend or is zero. For example, -7 / 2 gives quotient -3 and remainder -1, and -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R3: For a nonzero divisor, a start accepted at a clock edge behaves as follows. Busy is high from that edge until the edge 33 cycles later. At that later edge, done goes high for exactly one cycle, busy goes low, and the results are valid.
- R4: A start with a zero divisor raises done and the divide-by-zero flag at the very next edge. The quotient is all ones and the remainder equals the raw dividend, in either mode. Any completion with a nonzero divisor leaves the flag low.
- R5: A start that arrives while busy is high is ignored. The running division completes on its original schedule with the results of its original operands.
- R6: After reset, busy, done and the divide-by-zero flag are low, and quotient and remainder are zero.
- R7: Quotient, remainder and the divide-by-zero flag keep their values between completions, whatever the operand inputs do.
- R8: Unsigned operands with bit 31 set are divided correctly, including a divisor at or above 2^31 and a dividend of all ones. The partial remainder can reach 33 bits, and the comparison is 33 bits wide so that no carry is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division; sampled only when idle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend, sampled with an accepted start |
| divisor_i | input | 32 | Divisor, sampled with an accepted start |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse: results updated |
| quot_o | output | 32 | Quotient of the last completed division |
| rem_o | output | 32 | Remainder of the last completed division |
| dbz_o | output | 1 | Last completed division had a zero divisor |

## Verification
The case hardest to reach from the ports is the one where the partial remainder carries into a 33rd bit mid-loop. That only happens for unsigned divisors at or above 2^31 combined with large dividends, and uniform random operands rarely land there. The stimulus therefore mixes directed operands with the top bits set, and it biases part of the random draws toward divisors with bit 31 forced high. A start raised in the middle of a running division is injected on purpose, and the bench then checks that both the latency and the results belong to the first operands. Back-to-back zero-divisor starts and signed extremes such as -2^31 / -1 are applied directly.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_abs.sv
module div_abs #(
  parameter int W = 32
) (
  input  logic         sgn_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o
);

  always_comb begin
    if (sgn_i && val_i[W-1]) mag_o = -val_i;
    else                     mag_o = val_i;
  end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_i,
  output logic load_o,
  output logic zload_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign load_o  = accept && !zero_i;
  assign zload_o = accept && zero_i;
  assign step_o  = (state_q == ST_RUN);
  assign fin_o   = (state_q == ST_FIN);
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (load_o) state_d = ST_RUN;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        cnt_d   = '0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_RUN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (step_o && cnt_q == '0)); // R3

endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);

  logic           top_q, top_d;
  logic [2*W-1:0] acc_q, acc_d;
  logic [W-1:0]   dvs_q, dvs_d;
  logic [W-1:0]   left;
  logic [W-1:0]   new_left;
  logic [W+1:0]   diff;
  logic           fits;

  assign left = acc_q[2*W-1:W];
  assign diff = {1'b0, top_q, left} - {2'b00, dvs_q};
  assign fits = !diff[W+1];

  always_comb begin
    top_d    = top_q;
    acc_d    = acc_q;
    dvs_d    = dvs_q;
    new_left = fits ? diff[W-1:0] : left;
    if (load_i) begin
      top_d = 1'b0;
      acc_d = {{(W-1){1'b0}}, mag_a_i, 1'b0};
      dvs_d = mag_b_i;
    end else if (step_i) begin
      {top_d, acc_d} = {new_left, acc_q[W-1:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= 1'b0;
      acc_q <= '0;
      dvs_q <= '0;
    end else if (load_i || step_i) begin
      top_q <= top_d;
      acc_q <= acc_d;
      dvs_q <= dvs_d;
    end
  end

  assign quot_o = acc_q[W-1:0];
  assign rem_o  = {top_q, left[W-1:1]};

  AST_PARTIAL_BELOW_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ({1'b0, top_q, left} < {1'b0, dvs_q, 1'b0})); // R8

  AST_FIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && fits) |-> !diff[W]); // R1

endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         dbz_o
);

  logic [1:0][W-1:0] ops, mags;
  logic              load, zload, step, fin;
  logic [W-1:0]      quot_raw, rem_raw;
  logic              neg_quot_q, neg_quot_d, neg_rem_q, neg_rem_d;
  logic [W-1:0]      quot_q, quot_d, rem_q, rem_d;
  logic              dbz_q, dbz_d, done_q, done_d, res_en;

  assign ops[0] = dividend_i;
  assign ops[1] = divisor_i;

  for (genvar g = 0; g < 2; g++) begin : g_abs
    div_abs #(.W(W)) i_abs (
      .sgn_i (signed_i),
      .val_i (ops[g]),
      .mag_o (mags[g])
    );
  end

  div_ctrl #(.W(W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .zero_i  (divisor_i == '0),
    .load_o  (load),
    .zload_o (zload),
    .step_o  (step),
    .fin_o   (fin),
    .busy_o  (busy_o)
  );

  div_core #(.W(W)) i_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .mag_a_i (mags[0]),
    .mag_b_i (mags[1]),
    .quot_o  (quot_raw),
    .rem_o   (rem_raw)
  );

  always_comb begin
    neg_quot_d = signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
    neg_rem_d  = signed_i && dividend_i[W-1];
    res_en     = fin || zload;
    done_d     = res_en;
    dbz_d      = zload;
    if (zload) begin
      quot_d = '1;
      rem_d  = dividend_i;
    end else begin
      quot_d = neg_quot_q ? -quot_raw : quot_raw;
      rem_d  = neg_rem_q  ? -rem_raw  : rem_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_quot_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else if (load) begin
      neg_quot_q <= neg_quot_d;
      neg_rem_q  <= neg_rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      rem_q  <= '0;
      dbz_q  <= 1'b0;
    end else if (res_en) begin
      quot_q <= quot_d;
      rem_q  <= rem_d;
      dbz_q  <= dbz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;
  assign dbz_o  = dbz_q;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R3

  AST_DBZ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    dbz_o |-> (quot_o == '1)); // R4

  AST_SIGNS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(neg_quot_q) && $stable(neg_rem_q))); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(dbz_o))); // R7

endmodule

// File: tb/test_div_unit.sv
module test_div_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, signed_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic         busy_o, done_o, dbz_o;
  logic [W-1:0] quot_o, rem_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  div_unit #(.W(W)) i_div_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .quot_o     (quot_o),
    .rem_o      (rem_o),
    .dbz_o      (dbz_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_quot(logic [W-1:0] a, logic [W-1:0] b, bit sg);
    longint sa, sb;
    if (b == '0) return '1;
    if (!sg) return a / b;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return W'(sa / sb);
  endfunction

  function automatic logic [W-1:0] exp_rem(logic [W-1:0] a, logic [W-1:0] b, bit sg);
    longint sa, sb;
    if (b == '0) return a;
    if (!sg) return a % b;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return W'(sa % sb);
  endfunction

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit sg, input string tag, input bit poke);
    int n;
    int lat;
    @(negedge clk);
    start_i    = 1'b1;
    signed_i   = sg;
    dividend_i = a;
    divisor_i  = b;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    if (b != '0) check(busy_o == 1'b1, "R3 busy after start", W'(busy_o), W'(1));
    while (!done_o && n < 100) begin
      if (poke && n == 10) begin
        start_i    = 1'b1;
        signed_i   = ~sg;
        dividend_i = 32'h1234_5678;
        divisor_i  = 32'h0000_0003;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    lat = (b == '0) ? 1 : 34;
    check(n == lat, {tag, " R3 latency"}, W'(n), W'(lat));
    check(busy_o == 1'b0, {tag, " R3 busy low at done"}, W'(busy_o), W'(0));
    check(quot_o == exp_quot(a, b, sg), {tag, " quotient"}, quot_o, exp_quot(a, b, sg));
    check(rem_o == exp_rem(a, b, sg), {tag, " remainder"}, rem_o, exp_rem(a, b, sg));
    check(dbz_o == (b == '0), {tag, " R4 dbz flag"}, W'(dbz_o), W'(b == '0));
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R3 done one cycle"}, W'(done_o), W'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q_hold, r_hold, a, b;
    bit sg;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    signed_i   = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    repeat (3) @(negedge clk);
    // R6 reset state
    check(busy_o == 1'b0, "R6 busy", W'(busy_o), W'(0));
    check(done_o == 1'b0, "R6 done", W'(done_o), W'(0));
    check(dbz_o == 1'b0, "R6 dbz", W'(dbz_o), W'(0));
    check(quot_o == '0, "R6 quotient", quot_o, '0);
    check(rem_o == '0, "R6 remainder", rem_o, '0);
    rst_n = 1'b1;

    // R1 unsigned directed
    run_div(32'd100, 32'd7, 1'b0, "R1 100/7", 1'b0);
    run_div(32'd5, 32'd9, 1'b0, "R1 small dividend", 1'b0);
    run_div(32'd12345, 32'd1, 1'b0, "R1 divide by one", 1'b0);
    // R2 signed directed
    run_div(-32'sd7, 32'sd2, 1'b1, "R2 -7/2", 1'b0);
    run_div(32'sd7, -32'sd2, 1'b1, "R2 7/-2", 1'b0);
    run_div(-32'sd7, -32'sd2, 1'b1, "R2 -7/-2", 1'b0);
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R2 min/-1", 1'b0);
    // R8 top bits set, unsigned
    run_div(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R8 max/big", 1'b0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 equal max", 1'b0);
    run_div(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R8 just below", 1'b0);
    run_div(32'hF000_0000, 32'h8000_0000, 1'b0, "R8 half", 1'b0);
    // R4 zero divisor, both modes, back to back
    run_div(32'hDEAD_BEEF, 32'd0, 1'b0, "R4 zero unsigned", 1'b0);
    run_div(32'h8000_0005, 32'd0, 1'b1, "R4 zero signed", 1'b0);
    run_div(32'd50, 32'd6, 1'b0, "R4 flag clears", 1'b0);
    // R5 start while busy ignored
    run_div(32'h0BAD_F00D, 32'd1000, 1'b0, "R5 poke unsigned", 1'b1);
    run_div(-32'sd99999, 32'sd77, 1'b1, "R5 poke signed", 1'b1);

    // R7 hold between completions
    q_hold = quot_o;
    r_hold = rem_o;
    repeat (5) begin
      @(negedge clk);
      dividend_i = $urandom;
      divisor_i  = 32'd0;
      signed_i   = ~signed_i;
    end
    check(quot_o == q_hold, "R7 quotient held", quot_o, q_hold);
    check(rem_o == r_hold, "R7 remainder held", rem_o, r_hold);
    check(dbz_o == 1'b0, "R7 dbz held", W'(dbz_o), W'(0));

    // R1 R2 R8 random mix
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 200; i++) begin
      a  = $urandom;
      b  = $urandom;
      sg = $urandom_range(0, 1);
      case ($urandom_range(0, 4))
        0: b = b & 32'h0000_00FF;
        1: b = b | 32'h8000_0000;
        2: a = a | 32'hC000_0000;
        3: if ($urandom_range(0, 7) == 0) b = '0;
        default: ;
      endcase
      run_div(a, b, sg, sg ? "R2 random" : "R1 R8 random", 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule